// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small serial EEPROM. Its storage is an on-chip array of 2^ADDR_W bytes (256 by default), organised in pages of 2^PAGE_W bytes (16 by default). SCL and SDA are sampled on the system clock through two-flop synchronizers. The block pulls SDA low through an open-drain enable and never drives it high. START, repeated START and STOP are decoded from the synchronized lines, and only the 7-bit device address set by a parameter is answered.

A write carries a byte address followed by data bytes. The data bytes collect in a page buffer and are committed to the array together, only when STOP arrives. A timed write cycle follows, and the block ignores the bus while it runs. A WP input, sampled once per write, can reject the whole write. Reads start at the current address pointer. A random read sets that pointer with a write header, then issues a repeated START. While the host keeps acknowledging, the block sends successive bytes. The bus is a bit-serial, clock-driven link, so there is no valid/ready stream at the edge: the host's SCL paces all transfers. The block can hold a read only through the host's own acknowledge choice.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset every byte of the array reads as 8'hFF and the address pointer is 0, so a current-address read returns 8'hFF.
- R2: The block pulls SDA low for ACK only when the 7 address bits after START equal DEV_ADDR (default 7'h50, seen on the bus as 8'hA0 for write and 8'hA1 for read). Any other address gets NoACK. SDA is never pulled low while SCL is high.
- R3: A byte write (START, 8'hA0, address, data, STOP) with each byte acknowledged stores the data byte. A later random read of that address returns it.
- R4: During a page write only the low PAGE_W bits of the pointer advance after each data byte. A write that starts at 8'h4E with bytes 61,62,63 stores them at 8'h4E, 8'h4F and 8'h40, and leaves 8'h50 unchanged.
- R5: If more than 2^PAGE_W data bytes arrive before STOP, the later bytes overwrite earlier buffer entries at the wrapped in-page positions.
- R6: Buffered data reaches the array only on STOP. A repeated START after data bytes discards them and starts no write cycle.
- R7: For TWR_CYC system clocks after a committing STOP, the block answers nothing, including its own address (NoACK). Once the cycle ends, it acknowledges again.
- R8: WP is sampled on the SCL falling edge that ends the byte-address ACK. If WP is 1 there, the first data byte gets NoACK, the array is unchanged, and no write cycle starts.
- R9: With WP at 0 every data byte of a write is acknowledged.
- R10: An address byte with R/W=1 returns the byte at the pointer and moves the pointer on by one. A NoACK followed by STOP returns the block to idle.
- R11: While the host acknowledges read bytes, the block sends consecutive locations. The read pointer wraps from the last address of the array to 0, not at a page end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| wp_i | input | 1 | Write protect, 1 rejects writes |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |

## Verification
The hardest state to reach from the pins is the window just after a committing STOP. While the write cycle runs, the block must refuse even its own address. The bench gets there by issuing a START and the device address right after the STOP, well inside a shortened TWR_CYC, and expects NoACK. It then polls again after the window has closed and expects ACK. Page wrap and the WP strobe instant are reached by stepping the exact byte counts and by changing WP only between transactions. Each result is then read back through random and sequential reads.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_ADR, S_ADR_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } eep_st_t;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_d  <= scl_ff[SYNC_N-1];
      sda_d  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 4,
  parameter int TWR_CYC = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_din,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic                     buf_clr,
  input  logic                     commit,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PDEPTH = 1 << PAGE_W;
  localparam int CW     = $clog2(TWR_CYC + 1);

  logic [7:0]               mem  [DEPTH];
  logic [7:0]               pbuf [PDEPTH];
  logic [PDEPTH-1:0]        pval;
  logic [ADDR_W-PAGE_W-1:0] pg;
  logic [CW-1:0]            wc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PDEPTH; i++) pbuf[i] <= 8'h00;
      pval   <= '0;
      pg     <= '0;
      wc_cnt <= '0;
    end else begin
      if (buf_clr) pval <= '0;
      if (buf_we) begin
        pbuf[buf_idx] <= buf_din;
        pval[buf_idx] <= 1'b1;
        pg            <= page;
      end
      if (commit) begin
        for (int i = 0; i < PDEPTH; i++)
          if (pval[i]) mem[{pg, PAGE_W'(i)}] <= pbuf[i];
        pval   <= '0;
        wc_cnt <= CW'(TWR_CYC);
      end else if (wc_cnt != '0) begin
        wc_cnt <= wc_cnt - 1'b1;
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = (wc_cnt != '0);
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         ADDR_W   = 8,
  parameter int         PAGE_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     bus_start,
  input  logic                     bus_stop,
  input  logic                     wp_i,
  input  logic                     busy,
  input  logic [7:0]               rd_data,
  output logic                     sda_oe,
  output logic                     buf_we,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_din,
  output logic [ADDR_W-PAGE_W-1:0] page,
  output logic                     buf_clr,
  output logic                     commit,
  output logic [ADDR_W-1:0]        rd_addr
);
  eep_st_t           st;
  logic [2:0]        bit_cnt;
  logic [7:0]        sh, tx;
  logic              full, ack_drv, prot, got, hack;
  logic [ADDR_W-1:0] ptr;

  assign buf_we  = (st == S_WR) && scl_fall && full && !prot && !bus_start && !bus_stop;
  assign buf_idx = ptr[PAGE_W-1:0];
  assign buf_din = sh;
  assign page    = ptr[ADDR_W-1:PAGE_W];
  assign buf_clr = bus_start;
  assign commit  = bus_stop && got && (st == S_WR || st == S_WR_ACK);
  assign rd_addr = ptr;
  assign sda_oe  = ack_drv | ((st == S_RD) & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; bit_cnt <= '0; sh <= '0; tx <= 8'hFF;
      full <= 1'b0; ack_drv <= 1'b0; prot <= 1'b0; got <= 1'b0;
      hack <= 1'b0; ptr <= '0;
    end else if (bus_start) begin
      ack_drv <= 1'b0; full <= 1'b0; bit_cnt <= '0; got <= 1'b0;
      st <= busy ? S_IDLE : S_DEV;
    end else if (bus_stop) begin
      ack_drv <= 1'b0; got <= 1'b0; st <= S_IDLE;
    end else if (scl_rise) begin
      if (st == S_DEV || st == S_ADR || st == S_WR) begin
        sh      <= {sh[6:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) full <= 1'b1;
      end else if (st == S_RD_ACK) begin
        hack <= ~sda_s;
      end
    end else if (scl_fall) begin
      unique case (st)
        S_DEV: if (full) begin
          full <= 1'b0;
          if (sh[7:1] == DEV_ADDR) begin ack_drv <= 1'b1; st <= S_DEV_ACK; end
          else st <= S_IDLE;
        end
        S_DEV_ACK: begin
          ack_drv <= 1'b0; bit_cnt <= '0;
          if (sh[0]) begin tx <= rd_data; ptr <= ptr + 1'b1; st <= S_RD; end
          else st <= S_ADR;
        end
        S_ADR: if (full) begin
          full <= 1'b0; ptr <= ADDR_W'(sh); ack_drv <= 1'b1; st <= S_ADR_ACK;
        end
        S_ADR_ACK: begin
          ack_drv <= 1'b0; bit_cnt <= '0; prot <= wp_i; st <= S_WR;
        end
        S_WR: if (full) begin
          full <= 1'b0;
          if (prot) st <= S_IDLE;
          else begin
            got <= 1'b1; ack_drv <= 1'b1; st <= S_WR_ACK;
            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
          end
        end
        S_WR_ACK: begin ack_drv <= 1'b0; bit_cnt <= '0; st <= S_WR; end
        S_RD: begin
          tx <= {tx[6:0], 1'b1}; bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) st <= S_RD_ACK;
        end
        S_RD_ACK: begin
          bit_cnt <= '0;
          if (hack) begin tx <= rd_data; ptr <= ptr + 1'b1; st <= S_RD; end
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         TWR_CYC  = 1000,
  parameter int         ADDR_W   = 8,
  parameter int         PAGE_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic busy, buf_we, buf_clr, commit;
  logic [PAGE_W-1:0]        buf_idx;
  logic [7:0]               buf_din, rd_data;
  logic [ADDR_W-PAGE_W-1:0] page;
  logic [ADDR_W-1:0]        rd_addr;

  eep_sync #(.SYNC_N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  eep_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .wp_i(wp_i), .busy(busy), .rd_data(rd_data), .sda_oe(sda_oe_o),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_din(buf_din), .page(page),
    .buf_clr(buf_clr), .commit(commit), .rd_addr(rd_addr)
  );

  eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_din(buf_din), .page(page), .buf_clr(buf_clr), .commit(commit),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: rtl/eep_i2c_target_chk.sv
module eep_i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic commit,
  input logic sda_oe,
  input logic scl_s
);
  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
  // R7
  commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);
  // R2
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind eep_i2c_target eep_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit),
  .sda_oe(sda_oe_o), .scl_s(scl_s)
);

// File: tb/eep_i2c_target_tb.sv
`timescale 1ns/1ps
module eep_i2c_target_tb;
  localparam int TWR = 400;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  int   n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  eep_i2c_target #(.TWR_CYC(TWR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .wp_i(wp), .sda_oe_o(sda_oe)
  );

  // address, data pairs for byte write then random read
  localparam logic [15:0] VEC [4] = '{16'h005A, 16'h37A5, 16'hFE3C, 16'h8100};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic b_start();
    sda_m = 1'b1; #40; scl = 1'b1; #40; sda_m = 1'b0; #40; scl = 1'b0; #40;
  endtask

  task automatic b_stop();
    sda_m = 1'b0; #40; scl = 1'b1; #40; sda_m = 1'b1; #40;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic nak);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #40; scl = 1'b1; #40; scl = 1'b0;
    end
    sda_m = 1'b1; #40; scl = 1'b1; #20; nak = sda_bus; #20; scl = 1'b0;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #40; scl = 1'b1; #20; b[i] = sda_bus; #20; scl = 1'b0;
    end
    sda_m = ~mack; #40; scl = 1'b1; #40; scl = 1'b0;
  endtask

  task automatic wait_wc();
    repeat (TWR + 300) @(posedge clk);
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] b);
    logic nk;
    b_start(); wr_byte(8'hA0, nk); wr_byte(a, nk);
    b_start(); wr_byte(8'hA1, nk); rd_byte(1'b0, b); b_stop();
  endtask

  task automatic poll(output logic nk);
    b_start(); wr_byte(8'hA0, nk); b_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic nk, n1, n2;
    logic [7:0] d;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset content, R2 own address acknowledged
    b_start(); wr_byte(8'hA1, nk); check("R2 own addr ack", {7'd0, nk}, 8'd0);
    rd_byte(1'b0, d); b_stop(); check("R1 reset byte", d, 8'hFF);

    // R2 foreign address
    b_start(); wr_byte(8'hA2, nk); b_stop(); check("R2 foreign nak", {7'd0, nk}, 8'd1);

    // R3 / R9 vector walk
    for (int k = 0; k < 4; k++) begin
      b_start(); wr_byte(8'hA0, nk); wr_byte(VEC[k][15:8], n1); wr_byte(VEC[k][7:0], n2); b_stop();
      check("R9 data ack wp low", {7'd0, n2}, 8'd0);
      wait_wc();
      rand_read(VEC[k][15:8], d);
      check("R3 byte write readback", d, VEC[k][7:0]);
    end

    // R7 busy window
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h05, nk); wr_byte(8'h77, nk); b_stop();
    poll(nk); check("R7 busy nak", {7'd0, nk}, 8'd1);
    wait_wc();
    poll(nk); check("R7 ack after cycle", {7'd0, nk}, 8'd0);
    rand_read(8'h05, d); check("R7 committed", d, 8'h77);

    // R4 page write, in-page increment
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h23, nk);
    wr_byte(8'h11, nk); wr_byte(8'h22, nk); wr_byte(8'h33, nk); b_stop(); wait_wc();
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h4E, nk);
    wr_byte(8'h61, nk); wr_byte(8'h62, nk); wr_byte(8'h63, nk); b_stop(); wait_wc();
    rand_read(8'h40, d); check("R4 wrap to page start", d, 8'h63);
    rand_read(8'h4F, d); check("R4 page end", d, 8'h62);
    rand_read(8'h50, d); check("R4 next page untouched", d, 8'hFF);

    // R5 overrun of the page buffer
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h60, nk);
    for (int i = 0; i < 18; i++) wr_byte(8'(i + 1), nk);
    b_stop(); wait_wc();
    rand_read(8'h60, d); check("R5 overwrite idx0", d, 8'h11);
    rand_read(8'h61, d); check("R5 overwrite idx1", d, 8'h12);
    rand_read(8'h62, d); check("R5 kept idx2", d, 8'h03);
    rand_read(8'h6F, d); check("R5 kept idx15", d, 8'h10);

    // R6 repeated START discards data
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h70, nk); wr_byte(8'h99, nk);
    b_start(); wr_byte(8'hA1, nk); rd_byte(1'b0, d); b_stop();
    poll(nk); check("R6 no write cycle", {7'd0, nk}, 8'd0);
    rand_read(8'h70, d); check("R6 discarded", d, 8'hFF);

    // R8 write protect
    wp = 1'b1;
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h10, nk); wr_byte(8'hEE, nk); b_stop();
    wp = 1'b0;
    check("R8 data nak", {7'd0, nk}, 8'd1);
    poll(nk); check("R8 no write cycle", {7'd0, nk}, 8'd0);
    rand_read(8'h10, d); check("R8 memory unchanged", d, 8'hFF);

    // R10 current-address read follows pointer
    rand_read(8'h23, d); check("R10 random read", d, 8'h11);
    b_start(); wr_byte(8'hA1, nk); rd_byte(1'b0, d); b_stop();
    check("R10 current address", d, 8'h22);
    poll(nk); check("R10 idle after nak stop", {7'd0, nk}, 8'd0);

    // R11 sequential read and whole-memory wrap
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'h4E, nk);
    b_start(); wr_byte(8'hA1, nk);
    rd_byte(1'b1, d); check("R11 seq 4E", d, 8'h61);
    rd_byte(1'b1, d); check("R11 seq 4F", d, 8'h62);
    rd_byte(1'b0, d); check("R11 crosses page 50", d, 8'hFF);
    b_stop();
    b_start(); wr_byte(8'hA0, nk); wr_byte(8'hFE, nk);
    b_start(); wr_byte(8'hA1, nk);
    rd_byte(1'b1, d); check("R11 seq FE", d, 8'h3C);
    rd_byte(1'b1, d); check("R11 seq FF", d, 8'hFF);
    rd_byte(1'b0, d); check("R11 wrap to 00", d, 8'h5A);
    b_stop();

    // R1 reset again restores erased content
    rst_n = 1'b0; repeat (4) @(posedge clk); rst_n = 1'b1; repeat (4) @(posedge clk);
    rand_read(8'h05, d); check("R1 erased after reset", d, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule